// File: doc/BRIEF.md
# Reusable Saved-Register-Set Flag Tracker

This block records, for each of two privilege levels (supervisor and machine), whether the copy of each tracked register group that an interrupt handler left on its stack is still current. The handler epilog sets these flags through a set-bits/clear-bits port before it returns. The block then watches the retired register-file write ports, the retire strobe and the return strobe. It clears a flag as soon as the saved copy stops matching the live registers. The next interrupt prolog reads the flags and skips re-saving any group whose flag is still set.

There are two register groups. Group 0 covers x16 to x31. Group 1 covers x1 and x3 to x15. Registers x0 and x2 (the stack pointer) belong to no group. A mode input picks one of two clearing policies. In the minimal policy, any retired instruction after the return invalidates everything. In the tracked policy, only a write to a group invalidates that group. In both policies, a return that finds an interrupt pending and enabled is turned into interrupt entry. The block reports this with a one-cycle chain pulse and leaves the flags intact, so the saved set can be reused.

Top module: `ssr_tracker`

## Requirements
- R1: After a synchronous active-low reset, every flag is 0, `stat_o` is 0, `chain_o` is 0 and `skip_save_o` is 0.
- R2: `stat_o` bit 0 is the supervisor group-0 flag, bit 1 is the supervisor group-1 flag, bit 2 is the machine group-0 flag, bit 3 is the machine group-1 flag, and bits 7:4 read 0.
- R3: When `csr_valid_i` is high, each group whose bit in `csr_mask_i` is 1 has the flag of level `csr_priv_i` (0 = supervisor, 1 = machine) set if `csr_set_i` is 1 or cleared if it is 0. The change is visible on `stat_o` in the next cycle.
- R4: A write-enabled retired write to x16..x31 on any port clears group 0 at both levels. A write to x1 or x3..x15 clears group 1 at both levels. Both take effect in the next cycle.
- R5: A write to x0 or x2, or a port with its write enable low, changes no flag.
- R6: When a hardware clear (R4, R8) and a CSR set hit the same flag in the same cycle, the flag ends up 0.
- R7: A return with `irq_s_i` or `irq_m_i` high chains into interrupt entry. `chain_o` is high for exactly the one cycle after the return strobe, and the return changes no flag.
- R8: With `min_mode_i` = 1, a cycle with `retire_i` high clears all flags. A return that does not chain clears all flags of the level given by `ret_priv_i`.
- R9: With `min_mode_i` = 0, neither a non-chaining return nor `retire_i` changes a flag.
- R10: In the cycle after `entry_valid_i`, `skip_save_o` holds the group flags that level `entry_priv_i` had in the cycle of the strobe. When `entry_valid_i` is low, `skip_save_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| min_mode_i | input | 1 | 1 = minimal clearing policy, 0 = tracked policy |
| wr_en_i | input | NUM_WP | Per-port retired register-write enable |
| wr_addr_i | input | NUM_WP*5 | Destination register per port, port 0 in the low bits |
| retire_i | input | 1 | A non-return instruction retired |
| csr_valid_i | input | 1 | Flag set/clear request |
| csr_set_i | input | 1 | 1 = set masked flags, 0 = clear them |
| csr_priv_i | input | 1 | Level addressed by the request (0 S, 1 M) |
| csr_mask_i | input | 2 | Group mask of the request |
| ret_valid_i | input | 1 | Return instruction retires |
| ret_priv_i | input | 1 | Level the return leaves (0 S, 1 M) |
| irq_s_i | input | 1 | Supervisor interrupt pending and enabled |
| irq_m_i | input | 1 | Machine interrupt pending and enabled |
| entry_valid_i | input | 1 | Interrupt entry, samples the flags |
| entry_priv_i | input | 1 | Level being entered (0 S, 1 M) |
| stat_o | output | 8 | Status byte of the flags |
| chain_o | output | 1 | Return was converted into interrupt entry |
| skip_save_o | output | 2 | Groups the prolog may skip saving |

## Verification
Every output of this block is registered, so each result is due exactly one clock edge after the stimulus. A flag update appears on `stat_o`, a chained return on `chain_o`, and an entry sample on `skip_save_o`. The bench drives inputs on the falling edge and waits for the next falling edge, so that exactly one rising edge lies between stimulus and check. It then compares against a bench model that advances on that same rising edge. The directed steps use this one-edge delay to catch a chain pulse that lasts too long or a flag change that arrives a cycle late.

// File: rtl/ssr_pkg.sv
// Shared constants and helpers for the saved-register-set flag tracker.
// Assumes a 32-entry integer register file with 5-bit register numbers.
package ssr_pkg;
    localparam int NGRP  = 2;   // tracked register groups
    localparam int NPRIV = 2;   // privilege levels: index 0 = S, 1 = M
    localparam int REGW  = 5;   // register number width
    localparam int STATW = 8;   // status byte width
    localparam int PRIVW = $clog2(NPRIV);

    typedef enum logic [PRIVW-1:0] {
        LVL_S = 1'b0,
        LVL_M = 1'b1
    } lvl_e;

    // Map a destination register to its group bit (bit 0: x16..x31, bit 1: x1,x3..x15).
    function automatic logic [NGRP-1:0] group_of(input logic [REGW-1:0] rd);
        logic [NGRP-1:0] g;
        g[0] = rd[REGW-1];
        g[1] = !rd[REGW-1] && (rd != 5'd0) && (rd != 5'd2);
        return g;
    endfunction
endpackage

// File: rtl/ssr_wr_decode.sv
// Folds all retired register-write ports into one per-group hit vector.
// Assumes the write ports carry only retired (architectural) writes.
module ssr_wr_decode
    import ssr_pkg::*;
#(
    parameter int NUM_WP = 2
) (
    input  logic [NUM_WP-1:0]      wr_en,
    input  logic [NUM_WP*REGW-1:0] wr_addr,
    output logic [NGRP-1:0]        grp_hit
);
    logic [NUM_WP-1:0][NGRP-1:0] port_hit;

    for (genvar w = 0; w < NUM_WP; w++) begin : g_port
        // Per-port group lookup, gated by that port's write enable.
        always_comb begin
            port_hit[w] = wr_en[w] ? group_of(wr_addr[w*REGW +: REGW]) : '0;
        end
    end

    // OR the per-port hits together for each group.
    always_comb begin
        grp_hit = '0;
        for (int w = 0; w < NUM_WP; w++) begin
            grp_hit = grp_hit | port_hit[w];
        end
    end
endmodule

// File: rtl/ssr_flag_bank.sv
// One privilege level's bank of reusable flags, one flag per register group.
// Hardware clears take priority over software set/clear in the same cycle.
module ssr_flag_bank
    import ssr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] hw_clr,
    input  logic [NGRP-1:0] sw_set,
    input  logic [NGRP-1:0] sw_clr,
    output logic [NGRP-1:0] flag_q
);
    for (genvar g = 0; g < NGRP; g++) begin : g_flag
        // Per-group flag: hardware clear first, then software set, then software clear.
        always_ff @(posedge clk) begin
            if (!rst_n)           flag_q[g] <= 1'b0;
            else if (hw_clr[g])   flag_q[g] <= 1'b0;
            else if (sw_set[g])   flag_q[g] <= 1'b1;
            else if (sw_clr[g])   flag_q[g] <= 1'b0;
        end

        // R6
        hw_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_clr[g] |=> !flag_q[g]);

        // R3
        sw_set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_set[g] && !hw_clr[g]) |=> flag_q[g]);

        // R3
        rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[g]) |-> $past(sw_set[g]));
    end
endmodule

// File: rtl/ssr_ret_ctl.sv
// Decides return chaining and the level-wide clears of the minimal policy.
// Assumes the pending inputs already include the interrupt-enable qualification.
module ssr_ret_ctl
    import ssr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             min_mode,
    input  logic             retire,
    input  logic             ret_valid,
    input  logic [PRIVW-1:0] ret_priv,
    input  logic             irq_s,
    input  logic             irq_m,
    output logic [NPRIV-1:0] lvl_clr,
    output logic             chain_q
);
    logic chain_now;

    // A return chains if any supervisor or machine interrupt is ready.
    always_comb begin
        chain_now = ret_valid && (irq_s || irq_m);
    end

    // Minimal policy: retire clears every level, a plain return clears its level.
    always_comb begin
        for (int p = 0; p < NPRIV; p++) begin
            lvl_clr[p] = min_mode && (retire ||
                         (ret_valid && !chain_now && (ret_priv == PRIVW'(p))));
        end
    end

    // Register the chain decision into a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= chain_now;
    end

    // R7
    chain_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q |-> $past(ret_valid && (irq_s || irq_m)));

    // R7
    chain_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && (irq_s || irq_m)) |=> chain_q);
endmodule

// File: rtl/ssr_tracker.sv
// Tracks per-level, per-group "saved copy still current" flags for interrupt
// handlers, clears them on register writes or returns, chains returns into
// pending interrupts and samples skip-save hints at interrupt entry.
// Assumes at most one return, one CSR request and one entry strobe per cycle.
module ssr_tracker
    import ssr_pkg::*;
#(
    parameter int NUM_WP = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   min_mode_i,
    input  logic [NUM_WP-1:0]      wr_en_i,
    input  logic [NUM_WP*REGW-1:0] wr_addr_i,
    input  logic                   retire_i,
    input  logic                   csr_valid_i,
    input  logic                   csr_set_i,
    input  logic                   csr_priv_i,
    input  logic [NGRP-1:0]        csr_mask_i,
    input  logic                   ret_valid_i,
    input  logic                   ret_priv_i,
    input  logic                   irq_s_i,
    input  logic                   irq_m_i,
    input  logic                   entry_valid_i,
    input  logic                   entry_priv_i,
    output logic [STATW-1:0]       stat_o,
    output logic                   chain_o,
    output logic [NGRP-1:0]        skip_save_o
);
    logic [NGRP-1:0]             grp_hit;
    logic [NPRIV-1:0]            lvl_clr;
    logic [NPRIV-1:0][NGRP-1:0]  flags;
    logic [NPRIV-1:0][NGRP-1:0]  hw_clr;
    logic [NPRIV-1:0][NGRP-1:0]  sw_set;
    logic [NPRIV-1:0][NGRP-1:0]  sw_clr;
    logic [NGRP-1:0]             skip_q;

    ssr_wr_decode #(.NUM_WP(NUM_WP)) wr_dec_i (
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .grp_hit (grp_hit)
    );

    ssr_ret_ctl ret_ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .min_mode  (min_mode_i),
        .retire    (retire_i),
        .ret_valid (ret_valid_i),
        .ret_priv  (ret_priv_i),
        .irq_s     (irq_s_i),
        .irq_m     (irq_m_i),
        .lvl_clr   (lvl_clr),
        .chain_q   (chain_o)
    );

    for (genvar p = 0; p < NPRIV; p++) begin : g_lvl
        // Route software requests and hardware clears to this level's bank.
        always_comb begin
            hw_clr[p] = grp_hit | {NGRP{lvl_clr[p]}};
            sw_set[p] = (csr_valid_i && csr_set_i && (csr_priv_i == p[0]))
                        ? csr_mask_i : '0;
            sw_clr[p] = (csr_valid_i && !csr_set_i && (csr_priv_i == p[0]))
                        ? csr_mask_i : '0;
        end

        ssr_flag_bank bank_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_clr (hw_clr[p]),
            .sw_set (sw_set[p]),
            .sw_clr (sw_clr[p]),
            .flag_q (flags[p])
        );
    end

    // Capture the entered level's flags as the prolog's skip-save hint.
    always_ff @(posedge clk) begin
        if (!rst_n)             skip_q <= '0;
        else if (entry_valid_i) skip_q <= flags[entry_priv_i];
    end

    assign skip_save_o = skip_q;
    assign stat_o      = STATW'(flags);

    // R10
    skip_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid_i |=> (skip_save_o == $past(flags[entry_priv_i])));

    // R10
    skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !entry_valid_i |=> $stable(skip_save_o));

    // R8
    min_retire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (min_mode_i && retire_i) |=> (stat_o == '0));

    // R4
    grp0_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_hit[0] |=> (!stat_o[0] && !stat_o[2]));

    // R2
    stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[STATW-1:NPRIV*NGRP] == '0);

    // R9
    tracked_ret_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!min_mode_i && !csr_valid_i && grp_hit == '0) |=> $stable(stat_o));
endmodule

// File: tb/ssr_tracker_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// compared against an independent behavioural model of the flags.
module ssr_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       min_mode_i = 1'b0;
    logic [1:0] wr_en_i = '0;
    logic [9:0] wr_addr_i = '0;
    logic       retire_i = 1'b0;
    logic       csr_valid_i = 1'b0;
    logic       csr_set_i = 1'b0;
    logic       csr_priv_i = 1'b0;
    logic [1:0] csr_mask_i = '0;
    logic       ret_valid_i = 1'b0;
    logic       ret_priv_i = 1'b0;
    logic       irq_s_i = 1'b0;
    logic       irq_m_i = 1'b0;
    logic       entry_valid_i = 1'b0;
    logic       entry_priv_i = 1'b0;
    logic [7:0] stat_o;
    logic       chain_o;
    logic [1:0] skip_save_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ssr_tracker #(.NUM_WP(2)) dut_i (.*);

    // Bench model: flag index = level*2 + group, matching the status layout.
    logic [3:0] m_flag;
    logic       m_chain;
    logic [1:0] m_skip;

    function automatic logic [1:0] bench_grp(input logic en, input logic [4:0] r);
        logic [1:0] g;
        g[0] = en && (r >= 5'd16);
        g[1] = en && (r == 5'd1 || (r >= 5'd3 && r <= 5'd15));
        return g;
    endfunction

    always @(posedge clk) begin
        logic [1:0] hit;
        logic       ch;
        logic [3:0] nxt;
        if (!rst_n) begin
            m_flag  <= '0;
            m_chain <= 1'b0;
            m_skip  <= '0;
        end else begin
            hit = bench_grp(wr_en_i[0], wr_addr_i[4:0]) | bench_grp(wr_en_i[1], wr_addr_i[9:5]);
            ch  = ret_valid_i && (irq_s_i || irq_m_i);
            nxt = m_flag;
            for (int i = 0; i < 4; i++) begin
                logic lvl;
                logic grp;
                logic clr;
                lvl = i[1];
                grp = i[0];
                clr = hit[grp] ||
                      (min_mode_i && retire_i) ||
                      (min_mode_i && ret_valid_i && !ch && ret_priv_i == lvl);
                if (clr) nxt[i] = 1'b0;
                else if (csr_valid_i && csr_priv_i == lvl && csr_mask_i[grp])
                    nxt[i] = csr_set_i;
            end
            if (entry_valid_i) m_skip <= entry_priv_i ? m_flag[3:2] : m_flag[1:0];
            m_chain <= ch;
            m_flag  <= nxt;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en_i = '0; wr_addr_i = '0; retire_i = 0; csr_valid_i = 0; csr_set_i = 0;
        csr_priv_i = 0; csr_mask_i = '0; ret_valid_i = 0; ret_priv_i = 0;
        irq_s_i = 0; irq_m_i = 0; entry_valid_i = 0; entry_priv_i = 0;
    endtask

    // One stimulus cycle: inputs already driven, wait one edge, leave idle.
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic csr(input bit set, input bit lvl, input logic [1:0] mask);
        csr_valid_i = 1; csr_set_i = set; csr_priv_i = lvl; csr_mask_i = mask;
        tick();
    endtask

    task automatic chk_stat(input logic [7:0] exp, input string tag);
        check(stat_o == exp, tag, stat_o, exp);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_stat(8'h00, "R1 stat");
        check(chain_o == 1'b0, "R1 chain", {7'd0, chain_o}, 8'h00);
        check(skip_save_o == 2'b00, "R1 skip", {6'd0, skip_save_o}, 8'h00);

        // R3 and R2: set both machine groups, then supervisor group 0
        csr(1, 1, 2'b11);
        chk_stat(8'h0C, "R3 set M");
        csr(1, 0, 2'b01);
        chk_stat(8'h0D, "R2 layout");

        // R5: writes to x0 and x2, and a disabled port, change nothing
        wr_en_i = 2'b11; wr_addr_i = {5'd2, 5'd0};
        tick();
        chk_stat(8'h0D, "R5 x0/x2");
        wr_en_i = 2'b00; wr_addr_i = {5'd20, 5'd5};
        tick();
        chk_stat(8'h0D, "R5 disabled port");

        // R4: port 1 writes x20, group 0 cleared at both levels
        wr_en_i = 2'b10; wr_addr_i = {5'd20, 5'd0};
        tick();
        chk_stat(8'h08, "R4 group0");
        csr(1, 0, 2'b11);
        csr(1, 1, 2'b11);
        wr_en_i = 2'b01; wr_addr_i = {5'd0, 5'd5};
        tick();
        chk_stat(8'h05, "R4 group1");

        // R6: CSR set of supervisor group 1 collides with a write to x7
        csr_valid_i = 1; csr_set_i = 1; csr_priv_i = 0; csr_mask_i = 2'b10;
        wr_en_i = 2'b01; wr_addr_i = {5'd0, 5'd7};
        tick();
        chk_stat(8'h05, "R6 hw clear wins");
        csr(0, 0, 2'b01);
        chk_stat(8'h04, "R3 clear S");

        // R7: supervisor return with only a machine interrupt chains
        csr(1, 0, 2'b11);
        csr(1, 1, 2'b11);
        min_mode_i = 1;
        ret_valid_i = 1; ret_priv_i = 0; irq_m_i = 1;
        tick();
        check(chain_o == 1'b1, "R7 chain pulse", {7'd0, chain_o}, 8'h01);
        chk_stat(8'h0F, "R7 flags kept");
        tick();
        check(chain_o == 1'b0, "R7 pulse one cycle", {7'd0, chain_o}, 8'h00);

        // R8: minimal policy, plain supervisor return, then any retire
        ret_valid_i = 1; ret_priv_i = 0;
        tick();
        chk_stat(8'h0C, "R8 plain return");
        check(chain_o == 1'b0, "R8 no chain", {7'd0, chain_o}, 8'h00);
        retire_i = 1;
        tick();
        chk_stat(8'h00, "R8 retire");

        // R9: tracked policy keeps flags over return and retire
        min_mode_i = 0;
        csr(1, 0, 2'b11);
        csr(1, 1, 2'b11);
        ret_valid_i = 1; ret_priv_i = 1;
        tick();
        chk_stat(8'h0F, "R9 return");
        retire_i = 1;
        tick();
        chk_stat(8'h0F, "R9 retire");

        // R10: entry samples the machine level, then holds while M changes
        csr(0, 0, 2'b10);
        entry_valid_i = 1; entry_priv_i = 1;
        tick();
        check(skip_save_o == 2'b11, "R10 sample M", {6'd0, skip_save_o}, 8'h03);
        csr(0, 1, 2'b11);
        check(skip_save_o == 2'b11, "R10 hold", {6'd0, skip_save_o}, 8'h03);
        entry_valid_i = 1; entry_priv_i = 0;
        tick();
        check(skip_save_o == 2'b01, "R10 sample S", {6'd0, skip_save_o}, 8'h01);

        // Random traffic against the bench model, tracked then minimal policy.
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            min_mode_i    = (n >= 2000);
            wr_en_i[0]    = ($urandom % 100) < 15;
            wr_en_i[1]    = ($urandom % 100) < 15;
            wr_addr_i     = 10'($urandom);
            retire_i      = ($urandom % 100) < 10;
            csr_valid_i   = ($urandom % 100) < 50;
            csr_set_i     = ($urandom % 100) < 70;
            csr_priv_i    = 1'($urandom);
            csr_mask_i    = 2'($urandom);
            ret_valid_i   = ($urandom % 100) < 15;
            ret_priv_i    = 1'($urandom);
            irq_s_i       = ($urandom % 100) < 25;
            irq_m_i       = ($urandom % 100) < 25;
            entry_valid_i = ($urandom % 100) < 20;
            entry_priv_i  = 1'($urandom);
            @(negedge clk);
            check(stat_o == {4'd0, m_flag}, "R3 random stat", stat_o, {4'd0, m_flag});
            check(chain_o == m_chain, "R7 random chain", {7'd0, chain_o}, {7'd0, m_chain});
            check(skip_save_o == m_skip, "R10 random skip", {6'd0, skip_save_o}, {6'd0, m_skip});
        end

        idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule